// File: doc/BRIEF.md
# Indexed DAC Register Write Sequencer

The sequencer turns logical register writes aimed at a video DAC into the byte-wide port accesses the DAC needs. The DAC's registers sit in a 16-bit index space behind a small group of byte ports. One logical write therefore becomes five port writes in a fixed order:

1. Raise the indirect-access control port.
2. Write the low index byte.
3. Write the high index byte.
4. Write the value.
5. Drop the control port again.

A second command kind runs a fixed clock-setup script of eight index/value pairs. The script's last two pairs load the PLL's two divider bytes. The m byte holds a 2-bit frequency-divide field in bits 7:6 and a 6-bit VCO count in bits 5:0. The n byte is the reference divide count. The sequencer passes both bytes through unchanged.

Commands arrive on a valid/ready handshake and are taken only while the sequencer is idle. The operands are captured when the command is accepted. Every port access occupies exactly one strobe cycle, and the accesses follow each other without gaps. Ready returns in the cycle after the final access.

Top module: `dac_idx_seq`

## Requirements
- R1: While reset is asserted and after its release, with no command accepted yet, cmd_ready is 1, port_we is 0, port_sel is 0 and port_wdata is 0.
- R2: An accepted register write (cmd_pll = 0) produces five consecutive strobe cycles. Port codes are 0 = control, 1 = index, 2 = data, 3 = mask. The writes are, in order: control←0x01, index←cmd_index[7:0], data←cmd_index[15:8], mask←cmd_value, control←0x00. The first strobe falls in the cycle after acceptance.
- R3: An accepted PLL command (cmd_pll = 1) produces eight back-to-back register writes, each with the five-access shape of R2, 40 strobe cycles in all. The index←value pairs are, in order: 0x06←0x02, 0x10←0x01, 0x70←0x01, 0x8F←0x1F, 0x03←0x00, 0x05←0x00, 0x20←m, 0x21←n.
- R4: In a PLL command, m is cmd_value and n is cmd_nref. Both are delivered bit for bit, so the divide field (m bits 7:6) and the VCO count (m bits 5:0) arrive intact.
- R5: cmd_ready is 0 from the cycle after acceptance through the last strobe cycle. It is 1 in the cycle right after the last strobe.
- R6: Input activity while busy has no effect: toggling cmd_valid, cmd_pll, cmd_index, cmd_value or cmd_nref changes neither the running sequence nor its operands, which are the values captured at acceptance.
- R7: port_we is 1 in every cycle in which cmd_ready is 0, and 0 with port_sel and port_wdata at 0 in every cycle in which cmd_ready is 1.
- R8: A command held valid across the end of a sequence is accepted in the first ready cycle, so exactly one idle cycle separates the two sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_pll | input | 1 | 1 = run PLL setup script, 0 = single register write |
| cmd_index | input | 16 | Register index for a single write |
| cmd_value | input | 8 | Value for a single write, or m byte for the PLL script |
| cmd_nref | input | 8 | n byte (reference divide count) for the PLL script |
| port_sel | output | 2 | Target port: 0 control, 1 index, 2 data, 3 mask |
| port_wdata | output | 8 | Byte written to the selected port |
| port_we | output | 1 | Write strobe, one cycle per access |

## Verification
Two events can coincide in one cycle: the end of a sequence and a waiting command. The final control-release strobe of one sequence shares its edge with the decision whether a command that has been held valid may start. The bench keeps cmd_valid high with fresh operands through the whole of a running sequence. It then relies on the cycle-accurate queue model to require one idle cycle followed immediately by the new command's control-raise strobe. The operands must be the ones present at the ready edge, not those seen while busy.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    PORT_CTRL  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2,
    PORT_MASK  = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    ST_CTL_ON  = 3'd0,
    ST_IDX_LO  = 3'd1,
    ST_IDX_HI  = 3'd2,
    ST_VAL     = 3'd3,
    ST_CTL_OFF = 3'd4
  } step_e;

  localparam int PLL_PAIRS = 8;

  // Fixed part of the clock-setup script; the two tail entries take the
  // caller's divider bytes.
  function automatic logic [23:0] pll_pair(input logic [2:0] k,
                                           input logic [7:0] m,
                                           input logic [7:0] n);
    logic [23:0] r;
    case (k)
      3'd0:    r = {16'h0006, 8'h02};
      3'd1:    r = {16'h0010, 8'h01};
      3'd2:    r = {16'h0070, 8'h01};
      3'd3:    r = {16'h008F, 8'h1F};
      3'd4:    r = {16'h0003, 8'h00};
      3'd5:    r = {16'h0005, 8'h00};
      3'd6:    r = {16'h0020, m};
      default: r = {16'h0021, n};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int PAIR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAIR_W-1:0] last_pair,
  output logic              busy,
  output step_e             step,
  output logic [PAIR_W-1:0] pair
);

  logic              busy_q, busy_d;
  step_e             step_q, step_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              en;

  assign en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    pair_d = pair_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        step_d = ST_CTL_ON;
        pair_d = '0;
      end
    end else if (step_q == ST_CTL_OFF) begin
      step_d = ST_CTL_ON;
      if (pair_q == last_pair) begin
        busy_d = 1'b0;
        pair_d = '0;
      end else begin
        pair_d = pair_q + 1'b1;
      end
    end else begin
      step_d = step_e'(step_q + 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= ST_CTL_ON;
      pair_q <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      step_q <= step_d;
      pair_q <= pair_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign pair = pair_q;

endmodule

// File: rtl/dac_seq_source.sv
module dac_seq_source
  import dac_seq_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DAT_W  = 8,
  parameter int PAIR_W = 3
) (
  input  logic              mode_pll,
  input  logic [PAIR_W-1:0] pair,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [DAT_W-1:0]  val_q,
  input  logic [DAT_W-1:0]  nref_q,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [DAT_W-1:0]  cur_val
);

  logic [23:0] scr;

  generate
    if (PAIR_W >= 3) begin : g_wide
      assign scr = pll_pair(pair[2:0], val_q[7:0], nref_q[7:0]);
    end else begin : g_narrow
      assign scr = pll_pair(3'(pair), val_q[7:0], nref_q[7:0]);
    end
  endgenerate

  always_comb begin
    if (mode_pll) begin
      cur_idx = IDX_W'(scr[23:8]);
      cur_val = DAT_W'(scr[7:0]);
    end else begin
      cur_idx = idx_q;
      cur_val = val_q;
    end
  end

endmodule

// File: rtl/dac_seq_port.sv
module dac_seq_port
  import dac_seq_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DAT_W = 8
) (
  input  logic             busy,
  input  step_e            step,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [DAT_W-1:0] cur_val,
  output logic [1:0]       sel,
  output logic [DAT_W-1:0] wdata,
  output logic             we
);

  localparam int HI_W = IDX_W - DAT_W;

  always_comb begin
    sel   = PORT_CTRL;
    wdata = '0;
    we    = busy;
    if (busy) begin
      case (step)
        ST_CTL_ON: begin
          sel   = PORT_CTRL;
          wdata = DAT_W'(1);
        end
        ST_IDX_LO: begin
          sel   = PORT_INDEX;
          wdata = cur_idx[DAT_W-1:0];
        end
        ST_IDX_HI: begin
          sel   = PORT_DATA;
          wdata = DAT_W'(cur_idx[IDX_W-1 -: HI_W]);
        end
        ST_VAL: begin
          sel   = PORT_MASK;
          wdata = cur_val;
        end
        default: begin
          sel   = PORT_CTRL;
          wdata = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dac_idx_seq.sv
module dac_idx_seq
  import dac_seq_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_pll,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [DAT_W-1:0] cmd_value,
  input  logic [DAT_W-1:0] cmd_nref,
  output logic [1:0]       port_sel,
  output logic [DAT_W-1:0] port_wdata,
  output logic             port_we
);

  localparam int PAIR_W = $clog2(PLL_PAIRS);

  logic              busy;
  step_e             step;
  logic [PAIR_W-1:0] pair;
  logic              accept;
  logic              mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DAT_W-1:0]  val_q, nref_q;
  logic [PAIR_W-1:0] last_pair;
  logic [IDX_W-1:0]  cur_idx;
  logic [DAT_W-1:0]  cur_val;

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;

  // Operand capture: enabled on acceptance only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
      val_q  <= '0;
      nref_q <= '0;
    end else if (accept) begin
      mode_q <= cmd_pll;
      idx_q  <= cmd_index;
      val_q  <= cmd_value;
      nref_q <= cmd_nref;
    end
  end

  assign last_pair = mode_q ? PAIR_W'(PLL_PAIRS - 1) : '0;

  dac_seq_ctrl #(.PAIR_W(PAIR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .last_pair (last_pair),
    .busy      (busy),
    .step      (step),
    .pair      (pair)
  );

  dac_seq_source #(.IDX_W(IDX_W), .DAT_W(DAT_W), .PAIR_W(PAIR_W)) u_src (
    .mode_pll (mode_q),
    .pair     (pair),
    .idx_q    (idx_q),
    .val_q    (val_q),
    .nref_q   (nref_q),
    .cur_idx  (cur_idx),
    .cur_val  (cur_val)
  );

  dac_seq_port #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_port (
    .busy    (busy),
    .step    (step),
    .cur_idx (cur_idx),
    .cur_val (cur_val),
    .sel     (port_sel),
    .wdata   (port_wdata),
    .we      (port_we)
  );

endmodule

// File: rtl/dac_idx_seq_chk.sv
module dac_idx_seq_chk #(
  parameter int DAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       port_sel,
  input logic [DAT_W-1:0] port_wdata,
  input logic             port_we
);

  // R7: strobe and ready are complementary
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    port_we != cmd_ready);

  // R5: acceptance drops ready and starts strobing next cycle
  p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && port_we));

  // R2: every sequence opens by raising the control port
  p_open_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_we) |-> (port_sel == 2'd0 && port_wdata == DAT_W'(1)));

  // R2: every sequence closes by releasing the control port
  p_close_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_we) |-> ($past(port_sel) == 2'd0 && $past(port_wdata) == '0));

  // R2: the mask write is followed by the control release
  p_mask_then_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && port_sel == 2'd3) |=> (port_we && port_sel == 2'd0 && port_wdata == '0));

  // R2: the index write follows a control write
  p_index_after_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && port_sel == 2'd1) |-> ($past(port_we) && $past(port_sel) == 2'd0));

endmodule

bind dac_idx_seq dac_idx_seq_chk #(.DAT_W(DAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .port_sel   (port_sel),
  .port_wdata (port_wdata),
  .port_we    (port_we)
);

// File: tb/dac_idx_seq_test.sv
module dac_idx_seq_test;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic       cmd_pll;
  logic [15:0] cmd_index;
  logic [7:0] cmd_value;
  logic [7:0] cmd_nref;
  logic [1:0] port_sel;
  logic [7:0] port_wdata;
  logic       port_we;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int strobes_seen = 0;
  int strobes_exp = 0;
  bit model_on = 0;
  bit done = 0;

  int    q_sel[$];
  int    q_dat[$];
  string q_tag[$];

  dac_idx_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_pll    (cmd_pll),
    .cmd_index  (cmd_index),
    .cmd_value  (cmd_value),
    .cmd_nref   (cmd_nref),
    .port_sel   (port_sel),
    .port_wdata (port_wdata),
    .port_we    (port_we)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cycles, act, exp);
    end
  endtask

  task automatic push_write(int idx, int val, string tag);
    q_sel.push_back(0); q_dat.push_back(1);               q_tag.push_back(tag);
    q_sel.push_back(1); q_dat.push_back(idx & 8'hFF);     q_tag.push_back(tag);
    q_sel.push_back(2); q_dat.push_back((idx >> 8) & 8'hFF); q_tag.push_back(tag);
    q_sel.push_back(3); q_dat.push_back(val);             q_tag.push_back(tag);
    q_sel.push_back(0); q_dat.push_back(0);               q_tag.push_back(tag);
    strobes_exp += 5;
  endtask

  // Reference model: one comparison per cycle, sampled at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (model_on && !done) begin
      bit exp_ready;
      exp_ready = (q_sel.size() == 0);
      check(exp_ready ? "R8" : "R5", int'(cmd_ready), int'(exp_ready), "ready");
      if (port_we) strobes_seen++;
      if (exp_ready) begin
        check("R7", int'(port_we), 0, "idle we");
        check("R7", int'(port_sel), 0, "idle sel");
        check("R7", int'(port_wdata), 0, "idle data");
      end else begin
        string t;
        t = q_tag.pop_front();
        check("R7", int'(port_we), 1, "busy we");
        check(t, int'(port_sel), q_sel.pop_front(), "sel");
        check(t, int'(port_wdata), q_dat.pop_front(), "data");
      end
      if (cmd_valid && exp_ready) begin
        if (cmd_pll) begin
          push_write(16'h0006, 8'h02, "R3");
          push_write(16'h0010, 8'h01, "R3");
          push_write(16'h0070, 8'h01, "R3");
          push_write(16'h008F, 8'h1F, "R3");
          push_write(16'h0003, 8'h00, "R3");
          push_write(16'h0005, 8'h00, "R3");
          push_write(16'h0020, int'(cmd_value), "R4");
          push_write(16'h0021, int'(cmd_nref), "R4");
        end else begin
          push_write(int'(cmd_index), int'(cmd_value), "R2");
        end
      end
    end
  end

  task automatic issue(bit pll, logic [15:0] idx, logic [7:0] v, logic [7:0] n);
    @(posedge clk); #2;
    cmd_valid = 1; cmd_pll = pll; cmd_index = idx; cmd_value = v; cmd_nref = n;
    do @(negedge clk); while (!cmd_ready);
  endtask

  task automatic drop();
    @(posedge clk); #2;
    cmd_valid = 0; cmd_pll = 0; cmd_index = 16'hDEAD; cmd_value = 8'hBE; cmd_nref = 8'hEF;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!cmd_ready);
    repeat (2) @(negedge clk);
  endtask

  // R6: noise on the command inputs while a sequence runs
  task automatic noise(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cmd_valid = i[0]; cmd_pll = ~i[1];
      cmd_index = 16'(i * 16'h1357); cmd_value = 8'(i * 37); cmd_nref = 8'(i * 11);
    end
    @(posedge clk); #2;
    cmd_valid = 0;
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_pll = 0; cmd_index = '0; cmd_value = '0; cmd_nref = '0;
    repeat (3) begin
      @(negedge clk);
      check("R1", int'(cmd_ready), 1, "reset ready");
      check("R1", int'(port_we), 0, "reset we");
      check("R1", int'(port_sel), 0, "reset sel");
      check("R1", int'(port_wdata), 0, "reset data");
    end
    @(posedge clk); #2;
    rst_n = 1;
    model_on = 1;
    repeat (3) @(negedge clk);

    // R2: plain writes with corner operands
    issue(0, 16'h1234, 8'h5A, 8'h00); drop(); wait_idle();
    issue(0, 16'hFFFF, 8'h00, 8'h00); drop(); wait_idle();
    issue(0, 16'h0000, 8'hFF, 8'h00); drop(); wait_idle();

    // R6: inputs churn while busy
    issue(0, 16'hA55A, 8'h3C, 8'h00); noise(4); wait_idle();

    // R3, R4: PLL script with divider corner values
    issue(1, 16'h0000, 8'hC5, 8'h09); drop(); wait_idle();
    issue(1, 16'hFFFF, 8'h3F, 8'hFF); noise(20); wait_idle();

    // R8: commands held valid back to back
    issue(0, 16'h0102, 8'h03, 8'h00);
    issue(1, 16'h0000, 8'h40, 8'h07);
    issue(0, 16'hBEEF, 8'h81, 8'h00);
    drop(); wait_idle();

    done = 1;
    check("R3", strobes_seen, strobes_exp, "total strobes");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3000000;
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule